// File: doc/BRIEF.md
# Serial Peripheral Master Engine with Self-Test Loopback

This block runs single-lane SPI transfers as a bus master. A controller places a data word on its inputs, chooses a slave, and raises a one-cycle start request. The engine then drives the serial clock, the outgoing data line and one active-low slave select for as many bits as the chosen length. It collects the incoming data line and returns the received word together with a one-cycle completion pulse.

Each transfer takes its settings from the configuration inputs at the moment it starts. These settings are the divide code for the serial clock, the word length (8, 16 or 32 bits), the bit order, the slave index and an internal loopback switch. With loopback on, the engine feeds its own outgoing bit stream back into the receiver. This lets the shifting path be tested with no device attached.

Top module: `spi_std_master`

## Requirements
- R1: After reset, and whenever no transfer is running, `sclk` is 0, `mosi` is 0, every `ss_n` bit is 1, and `busy` and `done` are 0.
- R2: The divide code `cfg_div` sets the serial clock period in input-clock cycles: codes 0, 1 and 2 give 2, 4 and 8; a code c from 3 to 130 gives 16·(c−2); codes above 130 give 2048. A transfer of L bits keeps `busy` high for exactly L times that period. `done` shows in the cycle after the last of those cycles.
- R3: The engine works in clock mode 0. `sclk` idles low, and the first bit is on `mosi` from the cycle after start. `mosi` changes only while `sclk` goes low and is stable when `sclk` rises. The incoming bit is captured at each rising `sclk`. There are exactly L rising edges per transfer.
- R4: When `cfg_lsb` is 0, bit L−1 of the word goes out and comes in first. When `cfg_lsb` is 1, bit 0 goes first. The received word is returned right-aligned in both orders.
- R5: `cfg_len` code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. `tx_data` bits at or above L are never sent. `rx_data` bits at or above L read 0.
- R6: During a transfer, exactly one `ss_n` bit is low: the bit whose index is `ss_sel`. That output stays unchanged from the cycle after start through the last busy cycle.
- R7: With `cfg_loop` set, the received word equals the low L bits of `tx_data`, and the `miso` pin has no effect.
- R8: A `start` while `busy` is high is ignored. The running transfer keeps its data, slave select, length and timing.
- R9: `done` is high for exactly one cycle, in the same cycle that `busy` first reads 0. `rx_data` holds the received word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Transfer request, taken only while idle |
| tx_data | input | 32 | Word to send, right-aligned |
| cfg_len | input | 2 | Word length code |
| cfg_div | input | 8 | Serial clock divide code |
| cfg_lsb | input | 1 | 1 = least significant bit first |
| cfg_loop | input | 1 | 1 = receive the outgoing stream internally |
| ss_sel | input | 5 | Index of the slave to select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Outgoing serial data |
| miso | input | 1 | Incoming serial data |
| ss_n | output | 32 | Active-low slave selects |

## Verification
The hardest situation to reach from the ports is a second start request that lands in the middle of a running transfer. Its data, slave index and settings all differ from those of the transfer in progress. The stimulus pulses `start` a few cycles after a transfer begins. The scoreboard keeps only the original transfer's expected word, and the slave model checks the bits it received. So any disturbance shows up as a wrong word, a changed select or a wrong cycle count. The extreme divide codes are also hard to reach, because their transfers are long. The bench runs the top legal code and one code above it, and checks that the run lengths match.

// File: rtl/spi_std_pkg.sv
// Shared constants and decode helpers for the serial master engine.
// Assumes a 32-bit data word and an 8-bit divide code.
package spi_std_pkg;

    localparam int WORD_W     = 32;
    localparam int DIV_CODE_W = 8;
    localparam int HALF_W     = 11;
    localparam int NBIT_W     = 6;

    typedef enum logic [1:0] {
        LEN_BYTE  = 2'd0,
        LEN_HALF  = 2'd1,
        LEN_WORD  = 2'd2,
        LEN_WORD2 = 2'd3
    } len_code_e;

    // Half of the serial clock period, in input-clock cycles.
    function automatic logic [HALF_W-1:0] half_cycles(input logic [DIV_CODE_W-1:0] code);
        logic [HALF_W-1:0] r;
        if (code < DIV_CODE_W'(3))
            r = HALF_W'(1) << code;
        else if (code <= DIV_CODE_W'(130))
            r = HALF_W'(code - DIV_CODE_W'(2)) << 3;
        else
            r = HALF_W'(1024);
        return r;
    endfunction

    // Number of bits in a transfer for a length code.
    function automatic logic [NBIT_W-1:0] len_bits(input logic [1:0] code);
        logic [NBIT_W-1:0] n;
        case (len_code_e'(code))
            LEN_BYTE: n = NBIT_W'(8);
            LEN_HALF: n = NBIT_W'(16);
            default:  n = NBIT_W'(32);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
// Half-period timer: while run is high, it pulses tick once every half input
// cycles. Assumes half >= 1. The count clears whenever run is low.
module spi_half_timer #(
    parameter int HALF_W = spi_std_pkg::HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);
    logic [HALF_W-1:0] cnt;

    // Tick on the last cycle of each half period.
    always_comb tick = run && (cnt == half - HALF_W'(1));

    // Count the cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + HALF_W'(1);
    end
endmodule

// File: rtl/spi_word_shifter.sv
// Transmit and receive shift registers. load captures the word, the length
// and the order. sample shifts one incoming bit in. advance moves on to the
// next outgoing bit. rx_word is the received word, right-aligned; it is
// complete once L samples have been taken since load.
module spi_word_shifter #(
    parameter int WORD_W = spi_std_pkg::WORD_W,
    parameter int NBIT_W = spi_std_pkg::NBIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic [NBIT_W-1:0] load_bits,
    input  logic              load_lsb,
    input  logic              sample,
    input  logic              advance,
    input  logic              serial_in,
    output logic              serial_out,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic              lsb_q;
    logic [NBIT_W-1:0] pad_q;

    // Outgoing bit comes from the end of the register that matches the order.
    always_comb serial_out = lsb_q ? tx_sr[0] : tx_sr[WORD_W-1];

    // Right-align the received word. An LSB-first word fills in from the top.
    always_comb rx_word = lsb_q ? (rx_sr >> pad_q) : rx_sr;

    // Load, shift out and shift in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
            lsb_q <= 1'b0;
            pad_q <= '0;
        end else if (load) begin
            lsb_q <= load_lsb;
            pad_q <= NBIT_W'(WORD_W) - load_bits;
            rx_sr <= '0;
            tx_sr <= load_lsb ? load_word
                              : (load_word << (NBIT_W'(WORD_W) - load_bits));
        end else begin
            if (sample)
                rx_sr <= lsb_q ? {serial_in, rx_sr[WORD_W-1:1]}
                               : {rx_sr[WORD_W-2:0], serial_in};
            if (advance)
                tx_sr <= lsb_q ? {1'b0, tx_sr[WORD_W-1:1]}
                               : {tx_sr[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_sel_decode.sv
// Decodes a slave index into active-low selects. Exactly one select is low
// while en is high, and all are high otherwise. Assumes NUM_SS >= 2.
module spi_sel_decode #(
    parameter int NUM_SS = 32,
    parameter int SS_W   = 5
) (
    input  logic              en,
    input  logic [SS_W-1:0]   sel,
    output logic [NUM_SS-1:0] ss_n
);
    // One comparator per select output.
    for (genvar i = 0; i < NUM_SS; i++) begin : g_sel
        assign ss_n[i] = ~(en && (sel == SS_W'(i)));
    end
endmodule

// File: rtl/spi_std_master.sv
// Single-lane SPI master engine in clock mode 0. A start while idle latches
// tx_data and the configuration, selects one slave and runs L bits at the
// chosen serial clock rate. The transfer ends with a one-cycle done pulse,
// in the cycle where busy drops. Assumes start is synchronous to clk.
module spi_std_master #(
    parameter int NUM_SS = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [spi_std_pkg::WORD_W-1:0]       tx_data,
    input  logic [1:0]                           cfg_len,
    input  logic [spi_std_pkg::DIV_CODE_W-1:0]   cfg_div,
    input  logic                                 cfg_lsb,
    input  logic                                 cfg_loop,
    input  logic [$clog2(NUM_SS)-1:0]            ss_sel,
    output logic                                 busy,
    output logic                                 done,
    output logic [spi_std_pkg::WORD_W-1:0]       rx_data,
    output logic                                 sclk,
    output logic                                 mosi,
    input  logic                                 miso,
    output logic [NUM_SS-1:0]                    ss_n
);
    import spi_std_pkg::*;

    localparam int SS_W = $clog2(NUM_SS);

    logic [HALF_W-1:0] half_q;
    logic [NBIT_W-1:0] nbits_q;
    logic [NBIT_W-1:0] bit_cnt;
    logic [SS_W-1:0]   sel_q;
    logic              loop_q;
    logic              tick;
    logic              last_bit;
    logic              accept;
    logic              rise_now;
    logic              fall_now;
    logic              shift_out;
    logic              shift_in;
    logic [WORD_W-1:0] rx_word;

    // Decode of the control events for this cycle.
    always_comb begin
        accept   = !busy && start;
        last_bit = (bit_cnt == nbits_q - NBIT_W'(1));
        rise_now = busy && tick && !sclk;
        fall_now = busy && tick && sclk;
        shift_in = loop_q ? mosi : miso;
    end

    // Output data line is held low while idle.
    always_comb mosi = busy && shift_out;

    // Transfer control: configuration latch, clock phase, bit count, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            sclk    <= 1'b0;
            rx_data <= '0;
            half_q  <= HALF_W'(1);
            nbits_q <= NBIT_W'(8);
            bit_cnt <= '0;
            sel_q   <= '0;
            loop_q  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                sclk    <= 1'b0;
                bit_cnt <= '0;
                half_q  <= half_cycles(cfg_div);
                nbits_q <= len_bits(cfg_len);
                sel_q   <= ss_sel;
                loop_q  <= cfg_loop;
            end else if (rise_now) begin
                sclk <= 1'b1;
            end else if (fall_now) begin
                sclk <= 1'b0;
                if (last_bit) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    rx_data <= rx_word;
                end else begin
                    bit_cnt <= bit_cnt + NBIT_W'(1);
                end
            end
        end
    end

    spi_half_timer #(.HALF_W(HALF_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .half  (half_q),
        .tick  (tick)
    );

    spi_word_shifter #(.WORD_W(WORD_W), .NBIT_W(NBIT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_word  (tx_data),
        .load_bits  (len_bits(cfg_len)),
        .load_lsb   (cfg_lsb),
        .sample     (rise_now),
        .advance    (fall_now && !last_bit),
        .serial_in  (shift_in),
        .serial_out (shift_out),
        .rx_word    (rx_word)
    );

    spi_sel_decode #(.NUM_SS(NUM_SS), .SS_W(SS_W)) u_sel (
        .en   (busy),
        .sel  (sel_q),
        .ss_n (ss_n)
    );
endmodule

// File: rtl/spi_std_master_chk.sv
// Protocol checker for spi_std_master, attached with bind. It watches only
// the ports.
module spi_std_master_chk #(
    parameter int NUM_SS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              sclk,
    input logic              mosi,
    input logic [NUM_SS-1:0] ss_n
);
    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !mosi && (&ss_n)));

    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot0(~ss_n) && ($countones(~ss_n) == 1));

    // R6
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ss_n));

    // R3
    mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    // R3
    mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

bind spi_std_master spi_std_master_chk #(.NUM_SS(NUM_SS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .sclk  (sclk),
    .mosi  (mosi),
    .ss_n  (ss_n)
);

// File: tb/spi_std_master_bench.sv
module spi_std_master_bench;
    localparam int NUM_SS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tx_data = '0;
    logic [1:0]  cfg_len = '0;
    logic [7:0]  cfg_div = '0;
    logic        cfg_lsb = 1'b0;
    logic        cfg_loop = 1'b0;
    logic [4:0]  ss_sel = '0;
    logic        busy, done, sclk, mosi;
    logic        miso = 1'b0;
    logic [31:0] rx_data;
    logic [31:0] ss_n;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];

    // Slave model state
    logic [31:0] s_word = '0;
    logic [31:0] s_rx = '0;
    int          s_len = 8;
    bit          s_lsb = 0;
    int          s_idx = 0;
    int          s_rises = 0;

    always #2 clk = ~clk;

    spi_std_master #(.NUM_SS(NUM_SS)) u_spi_std_master (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
        .cfg_len(cfg_len), .cfg_div(cfg_div), .cfg_lsb(cfg_lsb),
        .cfg_loop(cfg_loop), .ss_sel(ss_sel), .busy(busy), .done(done),
        .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int bit_pos(input int i);
        return s_lsb ? i : (s_len - 1 - i);
    endfunction

    // Slave model: captures mosi at rising sclk, launches miso at falling sclk
    always @(posedge sclk) begin
        s_rx[bit_pos(s_idx)] = mosi;
        s_idx++;
        s_rises++;
    end
    always @(negedge sclk) begin
        if (s_idx < s_len) miso = s_word[bit_pos(s_idx)];
    end

    // Scoreboard monitor: each done pops one expected word
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(rx_data == e, "R4/R5/R7/R9 rx_data at done", rx_data, e);
                check(busy == 1'b0, "R9 busy low with done", busy, 0);
            end
        end
    end

    function automatic int ratio_of(input int code);
        if (code < 3) return 2 << code;
        if (code <= 130) return 16 * (code - 2);
        return 2048;
    endfunction

    function automatic int bits_of(input int code);
        return (code == 0) ? 8 : (code == 1) ? 16 : 32;
    endfunction

    task automatic xfer(input logic [31:0] tx, input int len_code, input bit lsb,
                        input bit loop, input int div, input int sel,
                        input logic [31:0] sword, input bit poke, input string tag);
        int L, ratio, k;
        logic [31:0] mask, expw;
        L = bits_of(len_code);
        ratio = ratio_of(div);
        mask = (L == 32) ? 32'hFFFF_FFFF : ((32'h1 << L) - 1);
        expw = loop ? (tx & mask) : (sword & mask);
        exp_q.push_back(expw);
        s_word = sword; s_len = L; s_lsb = lsb; s_idx = 0; s_rises = 0; s_rx = '0;
        miso = sword[bit_pos(0)];
        @(negedge clk);
        tx_data = tx; cfg_len = 2'(len_code); cfg_lsb = lsb; cfg_loop = loop;
        cfg_div = 8'(div); ss_sel = 5'(sel); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 70000) begin
            if (k == 0) begin
                check(mosi == tx[lsb ? 0 : L-1], {tag, " R3 first bit on mosi"}, mosi, tx[lsb ? 0 : L-1]);
                check(ss_n == ~(32'h1 << sel), {tag, " R6 select"}, ss_n, ~(32'h1 << sel));
            end
            if (poke && k == 3) begin
                tx_data = ~tx; ss_sel = 5'(sel + 1); cfg_len = 2'd0; cfg_div = 8'd0;
                cfg_loop = ~loop; start = 1'b1;
            end
            if (poke && k == 4) start = 1'b0;
            if (poke && k == 6)
                check(ss_n == ~(32'h1 << sel), {tag, " R8 select kept"}, ss_n, ~(32'h1 << sel));
            @(negedge clk);
            k++;
        end
        check(k == L * ratio, {tag, " R2 busy cycles"}, k, L * ratio);
        check(s_rises == L, {tag, " R3 rising edges"}, s_rises, L);
        check(s_rx == (tx & mask), {tag, " R4/R5 bits seen by slave"}, s_rx, tx & mask);
        @(negedge clk);
        check(!done && !busy && (&ss_n) && !sclk && !mosi, {tag, " R1/R9 idle after"}, {busy, done, sclk, mosi}, 0);
        if (poke) begin
            repeat (8) @(negedge clk);
            check(!busy, {tag, " R8 no second transfer"}, busy, 0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!sclk && !mosi && !busy && !done, "R1 reset outputs", {sclk, mosi, busy, done}, 0);
        check(&ss_n, "R1 reset selects high", ss_n, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(&ss_n && !busy, "R1 idle after reset", ss_n, 32'hFFFF_FFFF);

        xfer(32'h0000_003C, 0, 0, 0, 0, 0,  32'h0000_00A5, 0, "msb8 /2");
        xfer(32'hFFFF_FF96, 0, 1, 0, 1, 5,  32'h1234_56C3, 0, "lsb8 /4");
        xfer(32'h0000_B00F, 1, 0, 0, 2, 31, 32'h0000_5AA1, 0, "msb16 /8");
        xfer(32'h8001_7F3E, 3, 1, 0, 3, 17, 32'hC0DE_1234, 0, "lsb32 /16");
        xfer(32'h1357_9BDF, 2, 0, 0, 4, 9,  32'hF00D_8001, 0, "msb32 /32");
        xfer(32'hDEAD_6C1B, 1, 0, 1, 0, 3,  32'hFFFF_FFFF, 0, "R7 loop msb16");
        xfer(32'hA1B2_C3D4, 2, 1, 1, 1, 12, 32'h0000_0000, 0, "R7 loop lsb32");
        xfer(32'h0000_4D71, 1, 0, 0, 1, 20, 32'h0000_2E9C, 1, "R8 start while busy");
        xfer(32'h0000_0081, 0, 0, 0, 130, 7, 32'h0000_0042, 0, "R2 code 130");
        xfer(32'h0000_0018, 0, 1, 0, 255, 30, 32'h0000_00E7, 0, "R2 code 255");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 every transfer completed", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule